// File: doc/BRIEF.md
# Configurable NaN Result Selector

This block decides what a floating-point datapath returns when one or more of its single-precision operands is Not-a-Number. It serves two shapes of operation. Two-operand arithmetic uses a and b. Three-operand fused multiply-add uses a and b as the multiplicands and c as the addend. A single convention bit switches the whole NaN policy. Under the newer convention, a set fraction MSB means quiet. Signaling inputs are quieted and their payload is kept, and the default NaN is 0x7FC00000. Under the older convention, a set fraction MSB means signaling, and every NaN result is replaced by the default NaN 0x7FBFFFFF.

The arithmetic unit alongside it supplies the operands and a flag saying that the product of the fused operation is infinity times zero. The selector then returns the NaN result word, a flag saying that the result is a NaN, and an invalid-operation flag. The arithmetic unit uses the result word only when the NaN flag is set. The selection logic is combinational. A strobe captures it into an output register, which holds its value between strobes.

Top module: `nan_pick_unit`

## Requirements
- R1: An operand is a NaN exactly when its 8 exponent bits (30..23) are all ones and its 23 fraction bits (22..0) are not all zero. Infinity, with exponent all ones and fraction zero, is not a NaN.
- R2: With `mode_2008`=1, a NaN with bit 22 set is quiet and one with bit 22 clear is signaling. With `mode_2008`=0 the meaning of bit 22 is reversed.
- R3: When `three_op`=0, the chosen operand is the first match in this list: a if signaling, b if signaling, a if quiet, b if quiet. In this mode, c and `mul_inf_zero` have no effect.
- R4: When `three_op`=1, operands are ranked c, a, b with `mode_2008`=1 and a, b, c with `mode_2008`=0. The first signaling NaN in rank order wins. If there is none, the first quiet NaN wins.
- R5: With `mode_2008`=1, the chosen NaN is output with bit 22 forced to 1, and its sign and all other bits are kept. A quiet NaN is therefore passed through unchanged.
- R6: With `mode_2008`=0, every NaN result is the word 0x7FBFFFFF, whatever the input payloads.
- R7: With `mode_2008`=1, the default NaN is 0x7FC00000. It is output for a fused operation whose product is infinity times zero when c is not a NaN.
- R8: When `three_op`=1 and `mul_inf_zero`=1, both the invalid flag and the NaN flag are set. If c is a NaN, the result is c quieted as in R5 with `mode_2008`=1, and the default NaN with `mode_2008`=0. If c is not a NaN, the result is the default NaN of the selected convention.
- R9: Invalid is set when any participating operand is a signaling NaN, or in the R8 case. Otherwise it is clear.
- R10: When no participating operand is a NaN and the R8 case does not apply, the NaN flag is 0, invalid is 0 and the result word is 0.
- R11: The outputs take the new result on the rising edge at which `in_valid` is 1, and hold their value on edges where it is 0. A synchronous `rst` clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Capture strobe for the current inputs |
| opnd_a | input | 32 | Operand a (first multiplicand in fused mode) |
| opnd_b | input | 32 | Operand b (second multiplicand in fused mode) |
| opnd_c | input | 32 | Operand c (addend, fused mode only) |
| three_op | input | 1 | 1 = three-operand fused operation, 0 = two-operand |
| mul_inf_zero | input | 1 | The fused product is infinity times zero |
| mode_2008 | input | 1 | 1 = newer NaN convention, 0 = older convention |
| res_value | output | 32 | Selected NaN result word, 0 when no NaN |
| res_nan | output | 1 | Result is a NaN |
| res_invalid | output | 1 | Invalid-operation flag |

## Verification
The properties assume that `mul_inf_zero` is raised only when a and b really are an infinity and a zero. As a result, the inf-times-zero case never has a NaN among the multiplicands. The sweep respects this by using only the values that are not NaN for a and b whenever it sets that flag in fused mode. All other combinations of a finite value, infinity, and NaNs with bit 22 set or clear are driven across both conventions and both operand counts. The hold property also assumes that the strobe is the only source of output updates. The bench therefore changes operands while the strobe is low and then looks for unchanged outputs.

// File: rtl/nan_pick_pkg.sv
package nan_pick_pkg;

    typedef struct packed {
        logic is_nan;
        logic is_snan;
    } cls_t;

    typedef enum logic [1:0] {
        OP_A = 2'd0,
        OP_B = 2'd1,
        OP_C = 2'd2
    } op_idx_t;

endpackage

// File: rtl/nan_classify.sv
module nan_classify
    import nan_pick_pkg::*;
#(
    parameter int unsigned EXP_W  = 8,
    parameter int unsigned FRAC_W = 23,
    localparam int unsigned BODY_W = EXP_W + FRAC_W
) (
    input  logic [BODY_W-1:0] body,
    input  logic              mode_2008,
    output cls_t              cls
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    always_comb begin
        exp_f       = body[BODY_W-1 -: EXP_W];
        frac_f      = body[FRAC_W-1:0];
        cls.is_nan  = (&exp_f) && (|frac_f);
        // signaling when the MSB disagrees with the convention's quiet polarity
        cls.is_snan = cls.is_nan && (frac_f[FRAC_W-1] != mode_2008);
    end
endmodule

// File: rtl/nan_select.sv
module nan_select
    import nan_pick_pkg::*;
#(
    parameter int unsigned NUM_OPS = 3
) (
    input  cls_t [NUM_OPS-1:0] cls,
    input  logic               three_op,
    input  logic               mode_2008,
    output logic               found,
    output op_idx_t            pick,
    output logic               any_snan
);
    op_idx_t          order_r [NUM_OPS];
    logic [NUM_OPS-1:0] use_r;
    logic             found_s;
    logic             found_q;

    always_comb begin
        // rank table
        if (!three_op) begin
            order_r[0] = OP_A; order_r[1] = OP_B; order_r[2] = OP_C;
            use_r      = 3'b011;
        end else if (mode_2008) begin
            order_r[0] = OP_C; order_r[1] = OP_A; order_r[2] = OP_B;
            use_r      = 3'b111;
        end else begin
            order_r[0] = OP_A; order_r[1] = OP_B; order_r[2] = OP_C;
            use_r      = 3'b111;
        end

        any_snan = 1'b0;
        found_s  = 1'b0;
        found_q  = 1'b0;
        pick     = OP_A;

        for (int r = 0; r < NUM_OPS; r++) begin
            if (use_r[r] && cls[order_r[r]].is_snan) begin
                any_snan = 1'b1;
                if (!found_s) begin
                    found_s = 1'b1;
                    pick    = order_r[r];
                end
            end
        end

        if (!found_s) begin
            for (int r = 0; r < NUM_OPS; r++) begin
                if (!found_q && use_r[r] && cls[order_r[r]].is_nan) begin
                    found_q = 1'b1;
                    pick    = order_r[r];
                end
            end
        end

        found = found_s || found_q;
    end
endmodule

// File: rtl/nan_shape.sv
module nan_shape #(
    parameter int unsigned EXP_W  = 8,
    parameter int unsigned FRAC_W = 23,
    localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic [WORD_W-1:0] chosen,
    input  logic              found,
    input  logic              mode_2008,
    input  logic              iz_case,
    input  logic [WORD_W-1:0] c_word,
    input  logic              c_nan,
    input  logic              any_snan,
    output logic [WORD_W-1:0] value,
    output logic              nan,
    output logic              inv
);
    localparam logic [WORD_W-1:0] QMASK = WORD_W'(1) << (FRAC_W - 1);

    logic [WORD_W-1:0] dflt;

    always_comb begin
        dflt = {1'b0, {EXP_W{1'b1}}, mode_2008, {(FRAC_W-1){~mode_2008}}};

        if (iz_case) begin
            nan   = 1'b1;
            inv   = 1'b1;
            value = (mode_2008 && c_nan) ? (c_word | QMASK) : dflt;
        end else if (found) begin
            nan   = 1'b1;
            inv   = any_snan;
            value = mode_2008 ? (chosen | QMASK) : dflt;
        end else begin
            nan   = 1'b0;
            inv   = any_snan;
            value = '0;
        end
    end
endmodule

// File: rtl/nan_pick_unit.sv
module nan_pick_unit
    import nan_pick_pkg::*;
#(
    parameter int unsigned EXP_W  = 8,
    parameter int unsigned FRAC_W = 23,
    localparam int unsigned WORD_W  = 1 + EXP_W + FRAC_W,
    localparam int unsigned NUM_OPS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] opnd_a,
    input  logic [WORD_W-1:0] opnd_b,
    input  logic [WORD_W-1:0] opnd_c,
    input  logic              three_op,
    input  logic              mul_inf_zero,
    input  logic              mode_2008,
    output logic [WORD_W-1:0] res_value,
    output logic              res_nan,
    output logic              res_invalid
);
    typedef struct packed {
        logic [WORD_W-1:0] value;
        logic              nan;
        logic              inv;
    } out_t;

    logic [NUM_OPS-1:0][WORD_W-1:0] opnds;
    cls_t [NUM_OPS-1:0]             cls;
    logic                           pick_found;
    op_idx_t                        pick_idx;
    logic                           any_snan;
    logic [WORD_W-1:0]              chosen;
    logic [WORD_W-1:0]              shp_value;
    logic                           shp_nan;
    logic                           shp_inv;
    out_t                           out_d;
    out_t                           out_q;

    assign opnds = {opnd_c, opnd_b, opnd_a};

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_cls
        nan_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .body      (opnds[i][WORD_W-2:0]),
            .mode_2008 (mode_2008),
            .cls       (cls[i])
        );
    end

    nan_select #(.NUM_OPS(NUM_OPS)) u_sel (
        .cls       (cls),
        .three_op  (three_op),
        .mode_2008 (mode_2008),
        .found     (pick_found),
        .pick      (pick_idx),
        .any_snan  (any_snan)
    );

    always_comb begin
        case (pick_idx)
            OP_B:    chosen = opnd_b;
            OP_C:    chosen = opnd_c;
            default: chosen = opnd_a;
        endcase
    end

    nan_shape #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_shape (
        .chosen    (chosen),
        .found     (pick_found),
        .mode_2008 (mode_2008),
        .iz_case   (three_op && mul_inf_zero),
        .c_word    (opnd_c),
        .c_nan     (cls[2].is_nan),
        .any_snan  (any_snan),
        .value     (shp_value),
        .nan       (shp_nan),
        .inv       (shp_inv)
    );

    always_comb begin
        out_d = out_q;
        if (in_valid) begin
            out_d.value = shp_value;
            out_d.nan   = shp_nan;
            out_d.inv   = shp_inv;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign res_value   = out_q.value;
    assign res_nan     = out_q.nan;
    assign res_invalid = out_q.inv;
endmodule

// File: rtl/nan_pick_chk.sv
module nan_pick_chk #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned FRAC_W = 23
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              three_op,
    input logic              mul_inf_zero,
    input logic              mode_2008,
    input logic [WORD_W-1:0] res_value,
    input logic              res_nan,
    input logic              res_invalid
);
    localparam logic [WORD_W-1:0] OLD_DFLT = 32'h7FBF_FFFF;

    assert_old_default_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !mode_2008) |=> (!res_nan || res_value == OLD_DFLT));

    assert_quiet_out_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode_2008) |=> (!res_nan || res_value[FRAC_W-1]));

    assert_infzero_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && three_op && mul_inf_zero) |=> (res_nan && res_invalid));

    assert_invalid_has_nan_R9: assert property (@(posedge clk) disable iff (rst)
        res_invalid |-> res_nan);

    assert_clean_zero_R10: assert property (@(posedge clk) disable iff (rst)
        !res_nan |-> (res_value == '0));

    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(res_value) && $stable(res_nan) && $stable(res_invalid)));

    assert_reset_R11: assert property (@(posedge clk)
        rst |=> (res_value == '0 && !res_nan && !res_invalid));
endmodule

bind nan_pick_unit nan_pick_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .three_op     (three_op),
    .mul_inf_zero (mul_inf_zero),
    .mode_2008    (mode_2008),
    .res_value    (res_value),
    .res_nan      (res_nan),
    .res_invalid  (res_invalid)
);

// File: tb/test_nan_pick_unit.sv
`timescale 1ns/1ps
module test_nan_pick_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] opnd_a = '0, opnd_b = '0, opnd_c = '0;
    logic        three_op = 1'b0, mul_inf_zero = 1'b0, mode_2008 = 1'b0;
    logic [31:0] res_value;
    logic        res_nan, res_invalid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    nan_pick_unit i_nan_pick_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c),
        .three_op(three_op), .mul_inf_zero(mul_inf_zero), .mode_2008(mode_2008),
        .res_value(res_value), .res_nan(res_nan), .res_invalid(res_invalid)
    );

    function automatic bit is_nan(logic [31:0] x);
        return (x[30:23] == 8'hFF) && (x[22:0] != 23'd0);
    endfunction

    function automatic bit is_sn(logic [31:0] x, bit m);
        return is_nan(x) && (x[22] ^ m);
    endfunction

    // expected {value, nan, invalid}
    function automatic logic [33:0] model(logic [31:0] a, logic [31:0] b, logic [31:0] c,
                                          bit three, bit mul, bit m);
        logic [31:0] dflt;
        logic [31:0] ord [3];
        int n;
        bit inv;
        int hit;
        dflt = m ? 32'h7FC0_0000 : 32'h7FBF_FFFF;
        if (three && mul) begin
            if (m && is_nan(c)) return {c | 32'h0040_0000, 2'b11};
            return {dflt, 2'b11};
        end
        if (!three) begin ord[0] = a; ord[1] = b; ord[2] = 32'd0; n = 2; end
        else if (m) begin ord[0] = c; ord[1] = a; ord[2] = b; n = 3; end
        else begin ord[0] = a; ord[1] = b; ord[2] = c; n = 3; end
        inv = 1'b0;
        hit = -1;
        for (int r = 0; r < n; r++)
            if (is_sn(ord[r], m)) begin inv = 1'b1; if (hit < 0) hit = r; end
        if (hit < 0)
            for (int r = 0; r < n; r++)
                if (hit < 0 && is_nan(ord[r])) hit = r;
        if (hit < 0) return {32'd0, 1'b0, inv};
        return {(m ? (ord[hit] | 32'h0040_0000) : dflt), 1'b1, inv};
    endfunction

    task automatic chk(string tag, logic [33:0] got, logic [33:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got value=%h nan=%0b inv=%0b expected value=%h nan=%0b inv=%0b",
                     tag, got[33:2], got[1], got[0], exp[33:2], exp[1], exp[0]);
        end
    endtask

    task automatic apply(logic [31:0] a, logic [31:0] b, logic [31:0] c,
                         bit three, bit mul, bit m);
        @(negedge clk);
        opnd_a = a; opnd_b = b; opnd_c = c;
        three_op = three; mul_inf_zero = mul; mode_2008 = m;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic string tag_of(logic [31:0] a, logic [31:0] b, logic [31:0] c,
                                     bit three, bit mul, bit m);
        if (three && mul) return "R8";
        if (!(is_nan(a) || is_nan(b) || (three && is_nan(c)))) return "R10";
        if (!m) return "R6";
        if (three) return "R4";
        return "R3";
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] vals [4];
        vals[0] = 32'h3F80_0000;
        vals[1] = 32'h7F80_0000;
        vals[2] = 32'hFFC0_0123;
        vals[3] = 32'h7F80_0456;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R11 reset", {res_value, res_nan, res_invalid}, 34'd0);

        // R1: infinity is not a NaN
        apply(32'h7F80_0000, 32'h3F80_0000, 32'd0, 1'b0, 1'b0, 1'b1);
        chk("R1 inf", {res_value, res_nan, res_invalid}, 34'd0);
        apply(32'h7F80_0001, 32'h3F80_0000, 32'd0, 1'b0, 1'b0, 1'b1);
        chk("R1 min nan", {res_value, res_nan, res_invalid}, {32'h7FC0_0001, 2'b11});

        // R2: polarity of bit 22
        apply(32'h7F80_0001, 32'd0, 32'd0, 1'b0, 1'b0, 1'b0);
        chk("R2 old quiet", {res_value, res_nan, res_invalid}, {32'h7FBF_FFFF, 2'b10});
        apply(32'h7FC0_0000, 32'd0, 32'd0, 1'b0, 1'b0, 1'b0);
        chk("R2 old signaling", {res_value, res_nan, res_invalid}, {32'h7FBF_FFFF, 2'b11});

        // R5: quieting keeps sign and payload
        apply(32'hFF81_2345, 32'd0, 32'd0, 1'b0, 1'b0, 1'b1);
        chk("R5 quieted", {res_value, res_nan, res_invalid}, {32'hFFC1_2345, 2'b11});
        apply(32'hFFC1_2345, 32'd0, 32'd0, 1'b0, 1'b0, 1'b1);
        chk("R5 passthrough", {res_value, res_nan, res_invalid}, {32'hFFC1_2345, 2'b10});

        // R3: c and mul flag ignored in two-operand mode
        apply(32'h3F80_0000, 32'h3F80_0000, 32'h7F80_0009, 1'b0, 1'b1, 1'b1);
        chk("R3 c ignored", {res_value, res_nan, res_invalid}, 34'd0);
        apply(32'h7FC0_00AA, 32'h7F80_00BB, 32'd0, 1'b0, 1'b0, 1'b1);
        chk("R3 sig b first", {res_value, res_nan, res_invalid}, {32'h7FC0_00BB, 2'b11});

        // R4: fused order c first in newer convention
        apply(32'h7FC0_00AA, 32'h3F80_0000, 32'h7FC0_00CC, 1'b1, 1'b0, 1'b1);
        chk("R4 c first", {res_value, res_nan, res_invalid}, {32'h7FC0_00CC, 2'b10});

        // R7: default NaN of newer convention
        apply(32'h7F80_0000, 32'h0000_0000, 32'h3F80_0000, 1'b1, 1'b1, 1'b1);
        chk("R7 default", {res_value, res_nan, res_invalid}, {32'h7FC0_0000, 2'b11});

        // R9: signaling b outranks quiet a and sets invalid
        apply(32'h7FC0_0001, 32'h7F80_0002, 32'h3F80_0000, 1'b1, 1'b0, 1'b1);
        chk("R9 sig b", {res_value, res_nan, res_invalid}, {32'h7FC0_0002, 2'b11});

        // R11: hold while strobe low
        @(negedge clk);
        opnd_a = 32'h7F80_0777; opnd_b = 32'h7F80_0888; three_op = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R11 hold", {res_value, res_nan, res_invalid}, {32'h7FC0_0002, 2'b11});

        // sweep
        for (int m = 0; m < 2; m++)
            for (int t = 0; t < 2; t++)
                for (int mu = 0; mu < 2; mu++)
                    for (int ia = 0; ia < 4; ia++)
                        for (int ib = 0; ib < 4; ib++)
                            for (int ic = 0; ic < 4; ic++) begin
                                if (t == 1 && mu == 1 && (ia >= 2 || ib >= 2)) continue;
                                apply(vals[ia], vals[ib], vals[ic], t[0], mu[0], m[0]);
                                chk(tag_of(vals[ia], vals[ib], vals[ic], t[0], mu[0], m[0]),
                                    {res_value, res_nan, res_invalid},
                                    model(vals[ia], vals[ib], vals[ic], t[0], mu[0], m[0]));
                            end

        // R11: reset clears a NaN result
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R11 reset again", {res_value, res_nan, res_invalid}, 34'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule